// File: doc/BRIEF.md
# Rectifier Sextant Switch Selector

This block produces the three gate signals of a unidirectional three-switch current-source rectifier stage. An upstream controller supplies the sextant in which the input current reference lies and a flag telling whether the modulation carrier is on its rising or falling half. In every valid sextant one input phase is held on a DC rail. The other two phases take turns connecting to the opposite rail: one during the rising half of the carrier and the other during the falling half. The fictitious DC link therefore sees one of two line-to-line voltages. The output stage inverts this link downstream.

The switch pair is chosen by the direction of the carrier slope, not by comparing a duty value. Commutation between the two modulated switches therefore happens only when the carrier turns, which is when the inverter sits in its zero-current state. A new sextant is accepted only at the carrier trough that opens a new period. A sextant code outside 1 to 6, or a low enable, switches every gate off and raises a fault flag. The gates, the rail flag and the fault flag are registered, one clock after the inputs they follow.

Top module: `rect_sextant_gate`

## Requirements
- R1: During reset and after it, until a period boundary has latched a valid sextant, all gates are off, the fault flag is 1 and the rail flag is 0.
- R2: The sextant input is latched only in a cycle where the carrier flag is 1 and was 0 in the previous cycle. This is the trough at the start of a period. Sextant changes at any other time have no effect on the outputs.
- R3: The latched sextant selects the clamped phase. Sextants 1, 2, 3, 4, 5 and 6 clamp phase a, c, b, a, c and b respectively. The gate bus uses bit 0 for phase a, bit 1 for phase b and bit 2 for phase c.
- R4: With the carrier flag at 1 (rising half), the clamped gate and the gate of the next phase in the cycle a, b, c, a are on. With the flag at 0 (falling half), the clamped gate and the gate of the phase two steps after it are on.
- R5: The rail flag is 1 for odd sextants (clamp to the positive rail) and 0 for even sextants (clamp to the negative rail). It is 0 whenever the fault flag is 1.
- R6: Whenever the fault flag is 0, exactly two gates are on.
- R7: When the latched sextant is 0 or 7, or the enable is low, all gates are off and the fault flag is 1.
- R8: The outputs follow the inputs one clock edge later. No input reaches an output without a register.
- R9: While the fault flag stays 0, the gate pattern changes only in the cycle after the carrier flag toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low forces all gates off |
| sextant_i | input | 3 | Sextant index, valid values 1 to 6 |
| carrier_rise_i | input | 1 | 1 on the rising carrier half, 0 on the falling half |
| gate_o | output | 3 | Switch gates, bit 0 = phase a, bit 1 = b, bit 2 = c |
| clamp_pos_o | output | 1 | 1 for positive-rail clamping, 0 for negative |
| fault_o | output | 1 | All gates off because of disable or invalid sextant |

## Verification
A wrong latched sextant shows at the ports on the very next clock. The clamped gate or the rail flag is wrong for the whole carrier period, and is put right only at the following trough. A stale copy of the carrier flag shows as the modulated gate lagging a toggle by one cycle, or as a gate changing without a toggle. A fault decode error shows either as one gate alone, or as three gates on, in the cycle after the bad code is latched. The sweep visits every code, both carrier halves and both enable levels, and changes the sextant in mid-period to show that it is ignored.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned SEXT_W     = 3;
  localparam int unsigned NUM_PHASES = 3;
  localparam int unsigned IDX_W      = $clog2(NUM_PHASES);
  localparam int unsigned SEXT_FIRST = 1;
  localparam int unsigned SEXT_LAST  = 6;

  typedef logic [SEXT_W-1:0]     sext_t;
  typedef logic [IDX_W-1:0]      phase_idx_t;
  typedef logic [NUM_PHASES-1:0] gate_vec_t;
endpackage

// File: rtl/rsg_period_latch.sv
module rsg_period_latch
  import rsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_i,
  input  sext_t sext_i,
  output sext_t act_nxt_o,
  output logic  bound_o,
  output logic  turn_o
);
  logic  rise_q;
  sext_t act_q;

  assign bound_o   = rise_i & ~rise_q;
  assign turn_o    = rise_i ^ rise_q;
  assign act_nxt_o = bound_o ? sext_i : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      act_q  <= '0;
    end else begin
      rise_q <= rise_i;
      act_q  <= act_nxt_o;
    end
  end
endmodule

// File: rtl/rsg_phase_map.sv
module rsg_phase_map
  import rsg_pkg::*;
(
  input  sext_t     sext_i,
  input  logic      rise_i,
  input  logic      en_i,
  output gate_vec_t gate_o,
  output logic      pos_o,
  output logic      fault_o
);
  logic       in_range;
  logic       live;
  sext_t      km1;
  sext_t      rem3;
  phase_idx_t clamp_idx;
  phase_idx_t next_idx;
  phase_idx_t prev_idx;
  phase_idx_t mod_idx;

  always_comb begin
    in_range = (sext_i >= sext_t'(SEXT_FIRST)) && (sext_i <= sext_t'(SEXT_LAST));
    live     = in_range & en_i;
    km1      = sext_i - sext_t'(1);
    rem3     = (km1 >= sext_t'(NUM_PHASES)) ? km1 - sext_t'(NUM_PHASES) : km1;
    if (rem3 == '0) clamp_idx = '0;
    else            clamp_idx = phase_idx_t'(sext_t'(NUM_PHASES) - rem3);
    next_idx = (clamp_idx == phase_idx_t'(NUM_PHASES-1)) ? '0 : clamp_idx + phase_idx_t'(1);
    prev_idx = (clamp_idx == '0) ? phase_idx_t'(NUM_PHASES-1) : clamp_idx - phase_idx_t'(1);
    mod_idx  = rise_i ? next_idx : prev_idx;
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
    assign gate_o[p] = live & ((clamp_idx == phase_idx_t'(p)) | (mod_idx == phase_idx_t'(p)));
  end

  assign pos_o   = live & sext_i[0];
  assign fault_o = ~live;
endmodule

// File: rtl/rect_sextant_gate.sv
module rect_sextant_gate
  import rsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [2:0] sextant_i,
  input  logic       carrier_rise_i,
  output logic [2:0] gate_o,
  output logic       clamp_pos_o,
  output logic       fault_o
);
  sext_t     act_nxt;
  logic      bound;
  logic      turn;
  gate_vec_t gate_nxt;
  logic      pos_nxt;
  logic      fault_nxt;
  logic      bound_q;
  logic      turn_q;

  rsg_period_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (carrier_rise_i),
    .sext_i    (sextant_i),
    .act_nxt_o (act_nxt),
    .bound_o   (bound),
    .turn_o    (turn)
  );

  rsg_phase_map u_map (
    .sext_i  (act_nxt),
    .rise_i  (carrier_rise_i),
    .en_i    (en_i),
    .gate_o  (gate_nxt),
    .pos_o   (pos_nxt),
    .fault_o (fault_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_o      <= '0;
      clamp_pos_o <= 1'b0;
      fault_o     <= 1'b1;
      bound_q     <= 1'b0;
      turn_q      <= 1'b0;
    end else begin
      gate_o      <= gate_nxt;
      clamp_pos_o <= pos_nxt;
      fault_o     <= fault_nxt;
      bound_q     <= bound;
      turn_q      <= turn;
    end
  end

  AST_DARK_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (gate_o == 3'b000)); // R7

  AST_PAIR_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> ($countones(gate_o) == 2)); // R6

  AST_RAIL_AT_TROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_o && !$past(fault_o) && (clamp_pos_o != $past(clamp_pos_o))) |-> bound_q); // R2

  AST_COMMUTE_AT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_o && !$past(fault_o) && (gate_o != $past(gate_o))) |-> turn_q); // R9
endmodule

// File: tb/rect_sextant_gate_bench.sv
`timescale 1ns/1ps
module rect_sextant_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] sext = 3'd0;
  logic       rise = 1'b0;
  logic [2:0] gate;
  logic       pos;
  logic       fault;

  int tests = 0;
  int fails = 0;
  int act_m = 0;
  bit prev_rise = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rect_sextant_gate u_rect_sextant_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (en),
    .sextant_i      (sext),
    .carrier_rise_i (rise),
    .gate_o         (gate),
    .clamp_pos_o    (pos),
    .fault_o        (fault)
  );

  function automatic bit valid_m(int k, bit e);
    return e && (k >= 1) && (k <= 6);
  endfunction

  function automatic logic [2:0] exp_gate(int k, bit r, bit e);
    int cl;
    int other;
    if (!valid_m(k, e)) return 3'b000;
    cl    = (3 - ((k - 1) % 3)) % 3;
    other = r ? (cl + 1) % 3 : (cl + 2) % 3;
    return 3'(1 << cl) | 3'(1 << other);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (sextant %0d rise %0b en %0b)",
               req, act, exp, act_m, rise, en);
    end
  endtask

  task automatic check_all(string gate_req);
    bit v;
    v = valid_m(act_m, en);
    chk(gate_req, gate, exp_gate(act_m, rise, en));
    chk("R5", pos, (v && (act_m % 2 == 1)) ? 1 : 0);
    chk("R7", fault, v ? 0 : 1);
    if (v) chk("R6", $countones(gate), 2);
  endtask

  // inputs already set at a negedge; verify no combinational path, then clock once
  task automatic step(string gate_req);
    logic [2:0] held;
    held = gate;
    #1;
    chk("R8", gate, held);
    @(posedge clk);
    if (!prev_rise && rise) act_m = sext;
    prev_rise = rise;
    @(negedge clk);
    check_all(gate_req);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", gate, 0);
    chk("R1", fault, 1);
    chk("R1", pos, 0);
    rst_n = 1'b1;
    en = 1'b1;
    sext = 3'd1;
    step("R1");
    chk("R1", fault, 1);

    for (int e = 1; e >= 0; e--) begin
      for (int s = 0; s < 8; s++) begin
        en   = e[0];
        rise = 1'b0;
        sext = 3'(s);
        step("R3");
        rise = 1'b1;
        step("R4");
        sext = 3'((s + 5) % 8);
        step("R2");
        step("R9");
        rise = 1'b0;
        step("R4");
        step("R9");
      end
    end

    en = 1'b1;
    for (int s = 1; s <= 6; s++) begin
      sext = 3'(s);
      rise = 1'b1;
      step("R3");
      rise = 1'b0;
      sext = 3'(7 - s);
      step("R2");
    end
    sext = 3'd7;
    rise = 1'b1;
    step("R7");
    sext = 3'd2;
    rise = 1'b0;
    step("R7");
    rise = 1'b1;
    step("R3");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule